// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital state machine that decides how a LIN bus transceiver operates. It keeps one of four modes: standby, full-speed (normal slope) communication, reduced-slew (low slope) communication, and sleep. From that mode it derives the enables for the supply regulator and the bus transmitter, the slew-rate select, the choice between the resistive bus termination and the weak pull-up current source, the inhibit drive, and the source of the receive-data pin.

The enable, standby-control and transmit-data pins come from the host controller. They are asynchronous and pass through synchroniser chains before any edge is detected. Wake-up recognition is done elsewhere. It reaches this block as single-cycle pulses: one for a local wake pin event and one for a remote wake seen on the bus. A thermal shutdown flag overrides the regulator and the transmitter without changing the mode. The analog receiver output is passed to the receive-data pin whenever communication is active.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, the block is in standby. In that state `mode_stat`=00, `reg_en`=1, `tx_en`=0, `term_res`=0, `inh_drv`=0, `slope_low`=0 and `rxd_out`=1.
- R2: In standby, a rising edge of the synchronised enable pin while the synchronised transmit pin is 1 enters normal slope mode, with `slope_low`=0 and `tx_en`=1.
- R3: In standby, a rising edge of the enable pin while the transmit pin is 0 enters low slope mode, with `slope_low`=1. `tx_en` stays 0 until the synchronised transmit pin is first seen at 1. It then stays 1 for the rest of that low slope session.
- R4: `inh_drv` is 1 in a communication mode only if the synchronised standby-control pin was 1 on the clock that left standby. It is 0 in standby and in sleep.
- R5: In either communication mode, a falling edge of the enable pin enters standby if the standby-control pin is 1, and enters sleep if it is 0.
- R6: In sleep, a `wake_local` or `wake_remote` pulse enters standby. Enable edges have no effect in sleep.
- R7: `reg_en` is 1 in every mode except sleep. `tx_en` can be 1 only in the two communication modes. While `therm_sd` is 1, both `reg_en` and `tx_en` are 0 in the same cycle, and the mode does not change.
- R8: `term_res` is 1 (resistor) in the communication modes and 0 (current source) in standby and sleep.
- R9: `rxd_out` equals `bus_rx` in the communication modes and is 1 in sleep. In standby it is 0 after a remote wake, whether that wake left sleep or arrived during standby. It is 1 otherwise, and it returns to 1 only when a communication mode is next entered. A local wake in standby has no effect.
- R10: Each control pin passes through SYNC_STAGES flip-flops, and edges are found against one further register. A pin change made between clock edges therefore changes the mode at the (SYNC_STAGES+1)-th rising edge after it, and not before. At most one mode transition happens per clock.
- R11: `mode_stat` encodes the mode as 00 = standby, 01 = normal slope, 10 = low slope, 11 = sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| therm_sd | input | 1 | Thermal shutdown flag |
| wake_local | input | 1 | One-cycle pulse: local wake event |
| wake_remote | input | 1 | One-cycle pulse: remote bus wake event |
| en_pin | input | 1 | Enable pin from host, asynchronous |
| stb_pin | input | 1 | Standby-control pin from host, asynchronous |
| txd_pin | input | 1 | Transmit data pin from host, asynchronous, low = dominant |
| bus_rx | input | 1 | Receiver comparator output |
| reg_en | output | 1 | Regulator enable |
| tx_en | output | 1 | Bus transmitter enable |
| slope_low | output | 1 | 1 selects reduced slew rate |
| term_res | output | 1 | 1 selects the resistive termination, 0 the current source |
| inh_drv | output | 1 | Inhibit pin high drive |
| rxd_out | output | 1 | Receive-data pin level |
| mode_stat | output | 2 | Encoded current mode |

## Verification
A wrong internal mode appears at once on `mode_stat`, on `term_res`, and in the choice between `bus_rx` and a fixed level on `rxd_out`. A lost transmit gate or a stale remote-wake flag shows only through `tx_en` or `rxd_out`, and only in the modes where those outputs depend on it. Because of this, the bench compares every output against a cycle-accurate reference model on every clock, so any divergence is reported in the cycle it first reaches a port. Synchroniser depth errors show up as a mode change one clock early or late relative to the pin change.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

   typedef enum logic [1:0] {
      MD_STANDBY = 2'b00,
      MD_NORM    = 2'b01,
      MD_LOW     = 2'b10,
      MD_SLEEP   = 2'b11
   } lin_mode_e;

   function automatic logic md_active(lin_mode_e m);
      return (m == MD_NORM) || (m == MD_LOW);
   endfunction

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      assert (STAGES >= 2) else $error("lin_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("lin_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = sh[STAGES-1];
   end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en_s,
   input  logic      stb_s,
   input  logic      txd_s,
   input  logic      wake_loc,
   input  logic      wake_rem,
   output lin_mode_e mode_q,
   output logic      tx_gate_q,
   output logic      inh_q,
   output logic      rwake_q
);

   logic en_d;
   logic en_rise, en_fall;

   assign en_rise = en_s & ~en_d;
   assign en_fall = ~en_s & en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d      <= 1'b0;
         mode_q    <= MD_STANDBY;
         tx_gate_q <= 1'b0;
         inh_q     <= 1'b0;
         rwake_q   <= 1'b0;
      end else begin
         en_d <= en_s;
         unique case (mode_q)
            MD_STANDBY: begin
               if (en_rise) begin
                  mode_q    <= txd_s ? MD_NORM : MD_LOW;
                  tx_gate_q <= txd_s;
                  inh_q     <= stb_s;
                  rwake_q   <= 1'b0;
               end else if (wake_rem) begin
                  rwake_q <= 1'b1;
               end
            end
            MD_NORM, MD_LOW: begin
               if (en_fall) begin
                  mode_q    <= stb_s ? MD_STANDBY : MD_SLEEP;
                  tx_gate_q <= 1'b0;
                  inh_q     <= 1'b0;
               end else if (txd_s) begin
                  tx_gate_q <= 1'b1;
               end
            end
            MD_SLEEP: begin
               if (wake_loc || wake_rem) begin
                  mode_q  <= MD_STANDBY;
                  rwake_q <= wake_rem;
               end
            end
            default: mode_q <= MD_STANDBY;
         endcase
      end
   end

   // R3: low slope entered from standby never starts with the transmitter on
   p_low_entry_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MD_STANDBY && mode_q == MD_LOW) |-> !tx_gate_q);

   // R4: the inhibit latch only rises on a departure from standby
   p_inh_from_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inh_q) |-> $past(mode_q) == MD_STANDBY);

   // R6: sleep leads only to sleep or standby
   p_sleep_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_SLEEP) |=> (mode_q == MD_SLEEP || mode_q == MD_STANDBY));

   // R9: the remote wake flag is never set in a communication mode
   p_rwake_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      md_active(mode_q) |-> !rwake_q);

endmodule

// File: rtl/lin_out_decode.sv
module lin_out_decode
   import lin_mode_pkg::*;
(
   input  lin_mode_e  mode,
   input  logic       tx_gate,
   input  logic       inh_l,
   input  logic       rwake,
   input  logic       therm,
   input  logic       bus_rx,
   output logic       reg_en,
   output logic       tx_en,
   output logic       slope_low,
   output logic       term_res,
   output logic       inh_drv,
   output logic       rxd_out,
   output logic [1:0] mode_stat
);

   logic act;
   assign act = md_active(mode);

   always_comb begin
      reg_en    = (mode != MD_SLEEP) && !therm;
      tx_en     = act && tx_gate && !therm;
      slope_low = (mode == MD_LOW);
      term_res  = act;
      inh_drv   = act && inh_l;
      if (act)                   rxd_out = bus_rx;
      else if (mode == MD_SLEEP) rxd_out = 1'b1;
      else                       rxd_out = !rwake;
      mode_stat = mode;
   end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       therm_sd,
   input  logic       wake_local,
   input  logic       wake_remote,
   input  logic       en_pin,
   input  logic       stb_pin,
   input  logic       txd_pin,
   input  logic       bus_rx,
   output logic       reg_en,
   output logic       tx_en,
   output logic       slope_low,
   output logic       term_res,
   output logic       inh_drv,
   output logic       rxd_out,
   output logic [1:0] mode_stat
);

   localparam int NPINS = 3;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("lin_mode_ctrl: SYNC_STAGES below 2");
   end

   logic [NPINS-1:0] pins_s;
   lin_mode_e        mode_q;
   logic             tx_gate_q, inh_q, rwake_q;

   lin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async ({txd_pin, stb_pin, en_pin}),
      .q_sync  (pins_s)
   );

   lin_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (por_n),
      .en_s      (pins_s[0]),
      .stb_s     (pins_s[1]),
      .txd_s     (pins_s[2]),
      .wake_loc  (wake_local),
      .wake_rem  (wake_remote),
      .mode_q    (mode_q),
      .tx_gate_q (tx_gate_q),
      .inh_q     (inh_q),
      .rwake_q   (rwake_q)
   );

   lin_out_decode u_dec (
      .mode      (mode_q),
      .tx_gate   (tx_gate_q),
      .inh_l     (inh_q),
      .rwake     (rwake_q),
      .therm     (therm_sd),
      .bus_rx    (bus_rx),
      .reg_en    (reg_en),
      .tx_en     (tx_en),
      .slope_low (slope_low),
      .term_res  (term_res),
      .inh_drv   (inh_drv),
      .rxd_out   (rxd_out),
      .mode_stat (mode_stat)
   );

   // R7: transmitter only with resistive termination, never during thermal shutdown
   p_tx_needs_active_r7: assert property (@(posedge clk) disable iff (!por_n)
      tx_en |-> term_res);
   p_therm_off_r7: assert property (@(posedge clk) disable iff (!por_n)
      therm_sd |-> (!reg_en && !tx_en));

   // R4: inhibit drive never outside communication
   p_inh_needs_active_r4: assert property (@(posedge clk) disable iff (!por_n)
      inh_drv |-> term_res);

   // R9: sleep holds the receive pin high
   p_rxd_sleep_r9: assert property (@(posedge clk) disable iff (!por_n)
      (mode_stat == 2'b11) |-> rxd_out);

   // R8: regulator stays up whenever communication termination is on
   p_term_reg_r8: assert property (@(posedge clk) disable iff (!por_n)
      (term_res && !therm_sd) |-> reg_en);

endmodule

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;

   localparam int SYNC = 2;
   localparam int WDOG = 20000;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic therm_sd = 1'b0, wake_local = 1'b0, wake_remote = 1'b0;
   logic en_pin = 1'b0, stb_pin = 1'b0, txd_pin = 1'b1, bus_rx = 1'b1;
   logic reg_en, tx_en, slope_low, term_res, inh_drv, rxd_out;
   logic [1:0] mode_stat;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lin_mode_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .por_n(por_n), .therm_sd(therm_sd),
      .wake_local(wake_local), .wake_remote(wake_remote),
      .en_pin(en_pin), .stb_pin(stb_pin), .txd_pin(txd_pin), .bus_rx(bus_rx),
      .reg_en(reg_en), .tx_en(tx_en), .slope_low(slope_low), .term_res(term_res),
      .inh_drv(inh_drv), .rxd_out(rxd_out), .mode_stat(mode_stat)
   );

   // reference model: 0 standby, 1 normal slope, 2 low slope, 3 sleep
   int m_mode = 0;
   bit m_gate = 0, m_inh = 0, m_rw = 0;
   bit qe[$], qs[$], qt[$];

   task automatic model_clear();
      qe.delete(); qs.delete(); qt.delete();
      for (int i = 0; i <= SYNC; i++) begin
         qe.push_back(1'b0); qs.push_back(1'b0); qt.push_back(1'b0);
      end
      m_mode = 0; m_gate = 0; m_inh = 0; m_rw = 0;
   endtask

   initial model_clear();

   always @(posedge clk) begin
      if (!por_n) begin
         model_clear();
      end else begin
         bit en_c, en_p, stb_c, txd_c;
         en_c  = qe[qe.size()-SYNC+1-1];
         en_p  = qe[qe.size()-SYNC-1];
         stb_c = qs[qs.size()-SYNC+1-1];
         txd_c = qt[qt.size()-SYNC+1-1];
         case (m_mode)
            0: if (en_c && !en_p) begin
                  m_mode = txd_c ? 1 : 2; m_gate = txd_c; m_inh = stb_c; m_rw = 0;
               end else if (wake_remote) m_rw = 1;
            1, 2: if (!en_c && en_p) begin
                  m_mode = stb_c ? 0 : 3; m_gate = 0; m_inh = 0;
               end else if (txd_c) m_gate = 1;
            default: if (wake_local || wake_remote) begin
                  m_mode = 0; m_rw = wake_remote;
               end
         endcase
         qe.push_back(en_pin); qs.push_back(stb_pin); qt.push_back(txd_pin);
         void'(qe.pop_front()); void'(qs.pop_front()); void'(qt.pop_front());
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(posedge clk) begin
      cyc++;
      #5;
      if (!done) begin
         bit act;
         act = (m_mode == 1 || m_mode == 2);
         chk("R11 mode_stat", mode_stat, m_mode);
         chk("R7 reg_en", reg_en, (m_mode != 3) && !therm_sd);
         chk("R7 tx_en", tx_en, act && m_gate && !therm_sd);
         chk("R3 slope_low", slope_low, m_mode == 2);
         chk("R8 term_res", term_res, act);
         chk("R4 inh_drv", inh_drv, act && m_inh);
         chk("R9 rxd_out", rxd_out, act ? bus_rx : (m_mode == 3 ? 1 : !m_rw));
      end
   end

   always @(posedge clk) begin
      if (cyc > WDOG && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic ticks(int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic at_neg();
      @(negedge clk);
   endtask

   task automatic pulse_wake(bit rem);
      at_neg();
      if (rem) wake_remote = 1'b1; else wake_local = 1'b1;
      at_neg();
      wake_remote = 1'b0; wake_local = 1'b0;
   endtask

   initial begin
      ticks(3);
      chk("R1 reset mode", mode_stat, 0);
      chk("R1 reset rxd", rxd_out, 1);
      at_neg(); por_n = 1'b1;
      ticks(1);
      chk("R1 first cycle mode", mode_stat, 0);
      chk("R1 first cycle reg_en", reg_en, 1);
      chk("R1 first cycle tx_en", tx_en, 0);
      ticks(4);

      // R10 latency and R2 normal slope entry with STB high
      at_neg(); txd_pin = 1; stb_pin = 1; en_pin = 1;
      ticks(2);
      chk("R10 no change after two edges", mode_stat, 0);
      ticks(1);
      chk("R10 change on third edge / R2", mode_stat, 1);
      chk("R2 tx_en", tx_en, 1);
      chk("R4 inh high", inh_drv, 1);
      for (int i = 0; i < 8; i++) begin
         at_neg(); bus_rx = i[0]; txd_pin = i[1];
      end
      ticks(1);
      chk("R9 rxd follows bus", rxd_out, bus_rx);

      // R5 back to standby
      at_neg(); txd_pin = 1; en_pin = 0;
      ticks(4);
      chk("R5 standby", mode_stat, 0);
      chk("R4 inh in standby", inh_drv, 0);

      // R3 low slope, STB low
      at_neg(); txd_pin = 0; stb_pin = 0;
      ticks(3);
      at_neg(); en_pin = 1;
      ticks(4);
      chk("R3 low slope mode", mode_stat, 2);
      chk("R3 tx held off", tx_en, 0);
      chk("R4 inh floating", inh_drv, 0);
      at_neg(); txd_pin = 1;
      ticks(4);
      chk("R3 tx on after TxD high", tx_en, 1);
      at_neg(); txd_pin = 0;
      ticks(4);
      chk("R3 tx stays on", tx_en, 1);

      // R7 thermal shutdown
      at_neg(); therm_sd = 1;
      ticks(1);
      chk("R7 therm reg_en", reg_en, 0);
      chk("R7 therm tx_en", tx_en, 0);
      chk("R7 therm keeps mode", mode_stat, 2);
      at_neg(); therm_sd = 0;

      // R5 sleep
      at_neg(); txd_pin = 1; en_pin = 0;
      ticks(4);
      chk("R5 sleep", mode_stat, 3);
      chk("R7 sleep reg_en", reg_en, 0);
      chk("R9 sleep rxd", rxd_out, 1);

      // R6 enable ignored in sleep
      at_neg(); en_pin = 1;
      ticks(5);
      chk("R6 en ignored in sleep", mode_stat, 3);
      at_neg(); en_pin = 0;
      ticks(4);

      // R6 / R9 remote wake
      pulse_wake(1);
      ticks(1);
      chk("R6 remote wake", mode_stat, 0);
      chk("R9 rxd low after remote wake", rxd_out, 0);
      pulse_wake(0);
      ticks(1);
      chk("R9 local wake in standby ignored", rxd_out, 0);

      // normal, then sleep, then local wake
      at_neg(); stb_pin = 1; en_pin = 1;
      ticks(4);
      chk("R9 flag cleared in normal", mode_stat, 1);
      at_neg(); stb_pin = 0; en_pin = 0;
      ticks(4);
      chk("R5 sleep again", mode_stat, 3);
      pulse_wake(0);
      ticks(1);
      chk("R6 local wake", mode_stat, 0);
      chk("R9 rxd high after local wake", rxd_out, 1);
      pulse_wake(1);
      ticks(1);
      chk("R9 remote wake in standby", rxd_out, 0);

      // reset mid-operation
      at_neg(); stb_pin = 1; en_pin = 1;
      ticks(4);
      at_neg(); por_n = 0;
      ticks(1);
      chk("R1 reset from normal", mode_stat, 0);
      at_neg(); por_n = 1; en_pin = 0;
      ticks(6);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule